// File: doc/BRIEF.md
# Interrupt Redirection Message Dispatcher

This block sits between a set of interrupt request lines and a message bus. Each line owns one entry in a small redirection table, loaded through a write port. An entry holds a mask bit, an 8-bit destination, an 8-bit vector, a 3-bit delivery mode and a destination-mode bit. When a line request is accepted, the block reads that line's entry and builds a 32-bit trigger-interrupt payload and a 64-bit target address. It then sends the messages one at a time over a valid/ready channel.

In physical destination mode the destination field is the target ID, and one message goes out. In logical destination mode the destination field is a bit mask. One message goes out for every set bit, addressed to that bit's index, lowest index first. Masked entries are dropped without a trace. Entries with a reserved delivery mode are dropped and flag an error pulse. While a fan-out is in progress the block reports busy and refuses new requests.

Top module: `irq_msg_dispatch`

## Requirements
- R1: A write with `cfg_we` high and `cfg_idx` below NUM_LINES stores `cfg_wdata` into that line's entry at the clock edge. The entry fields are: destination in bits 7:0, vector in 15:8, delivery mode in 18:16, destination mode in 19 and mask in 20. A write to an index at or above NUM_LINES is ignored. After reset every entry has the mask set and all other fields zero.
- R2: A request for a line whose entry has the mask bit set produces no message and no error pulse. The mask is checked before the delivery mode.
- R3: The payload of every message is: destination in bits 7:0, vector in 15:8, delivery mode in 18:16 and destination mode in 19, all copied from the entry. Bits 31:20 are zero.
- R4: For an unmasked entry with destination mode 0, exactly one message is sent, with target ID equal to the destination field.
- R5: For an unmasked entry with destination mode 1, one message is sent per set bit of the destination field. Each message's target ID is that bit's index, and the messages go out in ascending index order.
- R6: Delivery modes 3 and 6 produce no message. Instead `rsv_err` is high for exactly the one cycle that follows the accepting clock edge. Modes 0, 1, 2, 4, 5 and 7 are forwarded unchanged in the payload.
- R7: The message address is 0x2000_0000_0000_0000 OR (target ID × 4096). The offset within the 4 KiB window is 0.
- R8: A presented message keeps `msg_valid` high and `msg_addr` and `msg_data` unchanged until a cycle in which `msg_ready` is high. The next message of a fan-out appears only after that handshake.
- R9: `busy` is high, and `req_ready` low, from the cycle after an accepted request that yields messages until the cycle after its last handshake. A request is accepted on an edge where `req_valid` and `req_ready` are both high. A request held while busy waits and is accepted once `req_ready` returns high. After reset `busy`, `msg_valid` and `rsv_err` are low and `req_ready` is high.
- R10: A request whose `req_line` is at or above NUM_LINES is accepted and ignored: no message and no error.
- R11: The entry is captured on the accepting edge. A write to that entry in the same cycle or during the dispatch does not change the messages of that request.
- R12: An unmasked entry in logical mode with an all-zero destination sends no message, raises no error and leaves `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | IDX_W | Table entry index for the write |
| cfg_wdata | input | 21 | Entry value (layout in R1) |
| req_valid | input | 1 | Line request present |
| req_line | input | IDX_W | Index of the requesting line |
| req_ready | output | 1 | Request can be accepted this cycle |
| msg_valid | output | 1 | Message presented |
| msg_ready | input | 1 | Bus takes the presented message |
| msg_addr | output | 64 | Message target address |
| msg_data | output | 32 | Trigger-interrupt payload |
| busy | output | 1 | Fan-out in progress |
| rsv_err | output | 1 | One-cycle pulse for a reserved delivery mode |

## Verification
Two functions can meet in the same cycle: a table write and the acceptance of a request for that same line. A write can also meet a handshake in the middle of a fan-out. The bench provokes the first by driving `cfg_we` and `req_valid` for one line in one cycle. It provokes the second by holding `msg_ready` low during a logical fan-out while it rewrites the entry. In both cases the messages that go out must carry the old entry's targets and vector. A behavioural model compares valid, busy, address, data and the error pulse on every clock. Random backpressure also lands handshakes on the cycle in which a waiting request becomes acceptable.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;

    localparam int TGT_W   = 8;
    localparam int SEL_W   = $clog2(TGT_W);
    localparam int ADDR_W  = 64;
    localparam int DATA_W  = 32;
    localparam int WIN_BITS = 12;
    localparam logic [ADDR_W-1:0] MSG_PREFIX = 64'h2000_0000_0000_0000;
    localparam logic [WIN_BITS-1:0] TRIG_OFFSET = '0;

    // bit 20 mask, 19 destination mode, 18:16 delivery, 15:8 vector, 7:0 destination
    typedef struct packed {
        logic             mask;
        logic             dmode;
        logic [2:0]       dlv;
        logic [7:0]       vec;
        logic [TGT_W-1:0] dest;
    } redir_ent_t;

    localparam int ENT_W = $bits(redir_ent_t);

    function automatic logic dlv_reserved(input logic [2:0] mode);
        return (mode == 3'd3) || (mode == 3'd6);
    endfunction

endpackage

// File: rtl/irq_redir_table.sv
module irq_redir_table
    import irq_msg_pkg::*;
#(
    parameter int NUM_LINES = 24,
    parameter int IDX_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  redir_ent_t       wr_ent,
    input  logic [IDX_W-1:0] rd_idx,
    output redir_ent_t       rd_ent,
    output logic             rd_hit
);

    redir_ent_t ent_q [NUM_LINES];

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_ent
        redir_ent_t ent_d;
        always_comb begin
            ent_d = ent_q[g];
            if (wr_en && (wr_idx == IDX_W'(g))) begin
                ent_d = wr_ent;
            end
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q[g] <= '{mask: 1'b1, default: '0};
            end else begin
                ent_q[g] <= ent_d;
            end
        end
    end

    always_comb begin
        rd_ent = '0;
        rd_hit = 1'b0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_ent = ent_q[i];
                rd_hit = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_lowbit_pick.sv
module irq_lowbit_pick #(
    parameter int W     = 8,
    parameter int SEL_W = $clog2(W)
) (
    input  logic [W-1:0]     bits_in,
    output logic [SEL_W-1:0] sel,
    output logic             any
);

    always_comb begin
        sel = '0;
        any = |bits_in;
        for (int i = W - 1; i >= 0; i--) begin
            if (bits_in[i]) begin
                sel = SEL_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_msg_build.sv
module irq_msg_build
    import irq_msg_pkg::*;
(
    input  redir_ent_t         ent,
    input  logic [TGT_W-1:0]   target,
    output logic [ADDR_W-1:0]  addr,
    output logic [DATA_W-1:0]  data
);

    localparam int PAD_W = DATA_W - 20;

    always_comb begin
        addr = MSG_PREFIX
             | (ADDR_W'(target) << WIN_BITS)
             | ADDR_W'(TRIG_OFFSET);
        data = {{PAD_W{1'b0}}, ent.dmode, ent.dlv, ent.vec, ent.dest};
    end

endmodule

// File: rtl/irq_msg_dispatch.sv
module irq_msg_dispatch
    import irq_msg_pkg::*;
#(
    parameter int NUM_LINES = 24,
    parameter int IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [20:0]       cfg_wdata,
    input  logic              req_valid,
    input  logic [IDX_W-1:0]  req_line,
    output logic              req_ready,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [63:0]       msg_addr,
    output logic [31:0]       msg_data,
    output logic              busy,
    output logic              rsv_err
);

    typedef struct packed {
        logic             active;
        logic             phys;
        redir_ent_t       ent;
        logic [TGT_W-1:0] todo;
        logic             err;
    } disp_st_t;

    disp_st_t   st_q, st_d;
    redir_ent_t rd_ent;
    logic       rd_hit;
    logic [SEL_W-1:0] pick_sel;
    logic       pick_any;
    logic [TGT_W-1:0] target;

    irq_redir_table #(
        .NUM_LINES (NUM_LINES),
        .IDX_W     (IDX_W)
    ) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_we),
        .wr_idx (cfg_idx),
        .wr_ent (redir_ent_t'(cfg_wdata)),
        .rd_idx (req_line),
        .rd_ent (rd_ent),
        .rd_hit (rd_hit)
    );

    irq_lowbit_pick #(
        .W     (TGT_W),
        .SEL_W (SEL_W)
    ) u_pick (
        .bits_in (st_q.todo),
        .sel     (pick_sel),
        .any     (pick_any)
    );

    assign target = st_q.phys ? st_q.ent.dest : TGT_W'(pick_sel);

    irq_msg_build u_build (
        .ent    (st_q.ent),
        .target (target),
        .addr   (msg_addr),
        .data   (msg_data)
    );

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (st_q.active) begin
            if (msg_ready) begin
                if (st_q.phys || !pick_any) begin
                    st_d.active = 1'b0;
                    st_d.todo   = '0;
                end else begin
                    st_d.todo   = st_q.todo & (st_q.todo - TGT_W'(1));
                    st_d.active = |st_d.todo;
                end
            end
        end else if (req_valid && rd_hit && !rd_ent.mask) begin
            if (dlv_reserved(rd_ent.dlv)) begin
                st_d.err = 1'b1;
            end else begin
                st_d.ent    = rd_ent;
                st_d.phys   = !rd_ent.dmode;
                st_d.todo   = rd_ent.dmode ? rd_ent.dest : '0;
                st_d.active = !rd_ent.dmode || (|rd_ent.dest);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready = !st_q.active;
    assign msg_valid = st_q.active;
    assign busy      = st_q.active;
    assign rsv_err   = st_q.err;

endmodule

// File: rtl/irq_msg_dispatch_chk.sv
module irq_msg_dispatch_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        msg_valid,
    input logic        msg_ready,
    input logic [63:0] msg_addr,
    input logic [31:0] msg_data,
    input logic        busy,
    input logic        rsv_err
);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

    p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid && req_ready));

    p_pad_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> msg_data[31:20] == 12'h000);

    p_no_reserved_r6: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_data[18:16] != 3'd3) && (msg_data[18:16] != 3'd6));

    p_err_origin_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsv_err |-> $past(req_valid && req_ready) && !busy);

    p_addr_form_r7: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_addr[63:20] == 44'h200_0000_0000) && (msg_addr[11:0] == 12'h000));

    p_phys_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_data[19] |-> msg_addr[19:12] == msg_data[7:0]);

    p_logic_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && msg_data[19] |-> (msg_addr[19:15] == 5'd0) && msg_data[msg_addr[14:12]]);

endmodule

bind irq_msg_dispatch irq_msg_dispatch_chk u_chk (.*);

// File: tb/tb_irq_msg_dispatch.sv
module tb_irq_msg_dispatch;

    localparam int CLK_PERIOD = 10;
    localparam int NL = 24;
    localparam int IW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [IW-1:0] cfg_idx = '0;
    logic [20:0]   cfg_wdata = '0;
    logic          req_valid = 1'b0;
    logic [IW-1:0] req_line = '0;
    logic          req_ready;
    logic          msg_valid;
    logic          msg_ready = 1'b0;
    logic [63:0]   msg_addr;
    logic [31:0]   msg_data;
    logic          busy;
    logic          rsv_err;

    irq_msg_dispatch #(.NUM_LINES(NL)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_line(req_line),
        .req_ready(req_ready), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data), .busy(busy), .rsv_err(rsv_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [63:0] q_addr[$];
    logic [31:0] q_data[$];
    logic [20:0] m_tab[NL];
    bit          m_err;
    bit          m_was_busy;
    bit          m_e;
    logic [20:0] m_ent;

    function automatic logic [63:0] mk_addr(input int tgt);
        return 64'h2000_0000_0000_0000 | (64'(tgt) << 12);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            q_addr.delete();
            q_data.delete();
            m_err = 0;
            for (int i = 0; i < NL; i++) m_tab[i] = 21'h100000;
        end else begin
            m_was_busy = (q_addr.size() != 0);
            m_e = 0;
            if (m_was_busy && msg_ready) begin
                void'(q_addr.pop_front());
                void'(q_data.pop_front());
            end
            if (!m_was_busy && req_valid && int'(req_line) < NL) begin
                m_ent = m_tab[req_line];
                if (!m_ent[20]) begin
                    if (m_ent[18:16] == 3'd3 || m_ent[18:16] == 3'd6) begin
                        m_e = 1;
                    end else if (!m_ent[19]) begin
                        q_addr.push_back(mk_addr(int'(m_ent[7:0])));
                        q_data.push_back({12'h0, m_ent[19:0]});
                    end else begin
                        for (int b = 0; b < 8; b++) begin
                            if (m_ent[b]) begin
                                q_addr.push_back(mk_addr(b));
                                q_data.push_back({12'h0, m_ent[19:0]});
                            end
                        end
                    end
                end
            end
            if (cfg_we && int'(cfg_idx) < NL) m_tab[cfg_idx] = cfg_wdata;
            m_err = m_e;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk(msg_valid == (q_addr.size() != 0), "R8 msg_valid", 64'(msg_valid), 64'(q_addr.size() != 0));
            chk(busy == (q_addr.size() != 0), "R9 busy", 64'(busy), 64'(q_addr.size() != 0));
            chk(req_ready == (q_addr.size() == 0), "R9 req_ready", 64'(req_ready), 64'(q_addr.size() == 0));
            chk(rsv_err == m_err, "R6 rsv_err", 64'(rsv_err), 64'(m_err));
            if (msg_valid && q_addr.size() != 0) begin
                chk(msg_addr == q_addr[0], "R7 msg_addr", msg_addr, q_addr[0]);
                chk(msg_data == q_data[0], "R3 msg_data", 64'(msg_data), 64'(q_data[0]));
            end
        end
    end

    // ---------------- ready driver and handshake monitor ----------------
    int          rdy_mode = 0;   // 0 always ready, 1 pseudo-random, 2 held low
    logic [15:0] lfsr = 16'hACE1;
    logic [7:0]  tgt_log[$];
    logic [31:0] dat_log[$];
    int          err_n = 0;

    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (rdy_mode)
            0: msg_ready = 1'b1;
            1: msg_ready = lfsr[0] & lfsr[3];
            default: msg_ready = 1'b0;
        endcase
        if (rst_n && msg_valid && msg_ready) begin
            tgt_log.push_back(msg_addr[19:12]);
            dat_log.push_back(msg_data);
        end
        if (rst_n && rsv_err) err_n++;
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [20:0] ent(input bit m, input bit dm, input int dl, input int v, input int d);
        return {m, dm, 3'(dl), 8'(v), 8'(d)};
    endfunction

    task automatic wr(input int idx, input logic [20:0] val);
        cfg_we = 1; cfg_idx = IW'(idx); cfg_wdata = val;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic fire(input int line);
        bit acc;
        int guard = 0;
        req_line = IW'(line); req_valid = 1;
        do begin
            acc = req_ready;
            @(negedge clk);
            guard++;
        end while (!acc && guard < 2000);
        req_valid = 0;
    endtask

    task automatic drain();
        int guard = 0;
        while ((busy || msg_valid) && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic clear_logs();
        tgt_log.delete(); dat_log.delete(); err_n = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // reset state (R9)
        chk(!busy && !msg_valid && req_ready && !rsv_err, "R9 reset outputs",
            {60'h0, busy, msg_valid, req_ready, rsv_err}, 64'h2);
        // reset table is masked (R1, R2)
        clear_logs();
        fire(0); drain();
        chk(tgt_log.size() == 0 && err_n == 0, "R1 reset entry masked", 64'(tgt_log.size()), 64'h0);

        // physical delivery (R4, R1, R3)
        wr(3, ent(0, 0, 0, 8'h41, 8'h2A));
        clear_logs(); fire(3); drain();
        chk(tgt_log.size() == 1, "R4 physical count", 64'(tgt_log.size()), 64'h1);
        if (tgt_log.size() == 1) begin
            chk(tgt_log[0] == 8'h2A, "R4 physical target", 64'(tgt_log[0]), 64'h2A);
            chk(dat_log[0] == 32'h0000_412A, "R1 field placement", 64'(dat_log[0]), 64'h412A);
        end

        // logical fan-out ascending (R5)
        wr(4, ent(0, 1, 1, 8'h77, 8'hA5));
        clear_logs(); fire(4); drain();
        chk(tgt_log.size() == 4, "R5 logical count", 64'(tgt_log.size()), 64'h4);
        if (tgt_log.size() == 4)
            chk({tgt_log[0], tgt_log[1], tgt_log[2], tgt_log[3]} == 32'h00020507,
                "R5 ascending targets", {32'h0, tgt_log[0], tgt_log[1], tgt_log[2], tgt_log[3]}, 64'h00020507);

        // masked entry, also with reserved mode (R2)
        wr(7, ent(1, 0, 3, 8'h10, 8'h01));
        clear_logs(); fire(7); drain();
        chk(tgt_log.size() == 0 && err_n == 0, "R2 masked dropped", 64'(tgt_log.size() + err_n), 64'h0);

        // reserved modes and forwarded mode 7 (R6)
        wr(8, ent(0, 0, 3, 8'h20, 8'h02));
        wr(9, ent(0, 1, 6, 8'h21, 8'hFF));
        wr(10, ent(0, 0, 7, 8'h22, 8'h03));
        clear_logs(); fire(8); drain(); fire(9); drain(); fire(10); drain();
        chk(err_n == 2, "R6 error pulses", 64'(err_n), 64'h2);
        chk(tgt_log.size() == 1, "R6 only mode 7 forwarded", 64'(tgt_log.size()), 64'h1);
        if (dat_log.size() == 1)
            chk(dat_log[0][18:16] == 3'd7, "R6 mode kept", 64'(dat_log[0][18:16]), 64'h7);

        // out-of-range line and write (R10, R1)
        wr(27, ent(0, 0, 0, 8'h55, 8'h05));
        clear_logs(); fire(30); drain(); fire(27); drain();
        chk(tgt_log.size() == 0 && err_n == 0, "R10 out of range ignored", 64'(tgt_log.size()), 64'h0);

        // logical, empty mask (R12)
        wr(11, ent(0, 1, 0, 8'h30, 8'h00));
        clear_logs(); fire(11);
        chk(!busy, "R12 no busy", 64'(busy), 64'h0);
        drain();
        chk(tgt_log.size() == 0 && err_n == 0, "R12 nothing sent", 64'(tgt_log.size()), 64'h0);

        // backpressure during full fan-out (R8, R7)
        wr(12, ent(0, 1, 4, 8'h99, 8'hFF));
        rdy_mode = 1;
        clear_logs(); fire(12); drain();
        rdy_mode = 0;
        chk(tgt_log.size() == 8, "R8 all sent under stalls", 64'(tgt_log.size()), 64'h8);
        if (tgt_log.size() == 8)
            chk(tgt_log[7] == 8'd7, "R7 last target", 64'(tgt_log[7]), 64'h7);

        // busy blocks a second request (R9)
        rdy_mode = 2;
        clear_logs(); fire(3);
        req_line = IW'(4); req_valid = 1;
        repeat (5) begin
            chk(!req_ready && busy, "R9 stall while busy", {62'h0, req_ready, busy}, 64'h1);
            @(negedge clk);
        end
        rdy_mode = 0;
        begin
            int g = 0;
            while (!req_ready && g < 100) begin @(negedge clk); g++; end
        end
        @(negedge clk);
        req_valid = 0;
        drain();
        chk(tgt_log.size() == 5, "R9 waiting request served", 64'(tgt_log.size()), 64'h5);

        // rewrite during dispatch (R11)
        wr(5, ent(0, 1, 0, 8'h44, 8'h0C));
        rdy_mode = 2;
        clear_logs(); fire(5);
        wr(5, ent(0, 1, 0, 8'h66, 8'h81));
        rdy_mode = 0; drain();
        chk(tgt_log.size() == 2, "R11 old entry count", 64'(tgt_log.size()), 64'h2);
        if (tgt_log.size() == 2)
            chk(tgt_log[1] == 8'd3 && dat_log[1][15:8] == 8'h44, "R11 old entry content",
                {tgt_log[1], dat_log[1][15:8]}, 64'h0344);

        // write in the acceptance cycle of the same line (R11)
        wr(6, ent(0, 0, 2, 8'h11, 8'h09));
        clear_logs();
        cfg_we = 1; cfg_idx = IW'(6); cfg_wdata = ent(0, 0, 2, 8'h12, 8'h0A);
        req_line = IW'(6); req_valid = 1;
        @(negedge clk);
        cfg_we = 0; req_valid = 0;
        drain();
        chk(tgt_log.size() == 1 && tgt_log[0] == 8'h09, "R11 same-cycle write",
            64'(tgt_log.size() == 1 ? tgt_log[0] : 8'hEE), 64'h09);
        clear_logs(); fire(6); drain();
        chk(tgt_log.size() == 1 && tgt_log[0] == 8'h0A, "R1 new entry used later",
            64'(tgt_log.size() == 1 ? tgt_log[0] : 8'hEE), 64'h0A);

        // mixed random traffic checked by the model
        rdy_mode = 1;
        for (int n = 0; n < 40; n++) begin
            fire(n % 14);
        end
        drain();
        rdy_mode = 0;

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule